// File: doc/BRIEF.md
# Blocking Miss and Writeback Buffer

This block handles misses for a blocking cache. It holds exactly one miss entry and one write-buffer entry. It takes a miss from the cache, made of an address, a command, an uncacheable flag, a thread number and the write-allocate setting. It decides which entry the miss belongs in, stores the block-aligned address, and raises that resource's blocked flag and bus request. The cache takes no further misses until both entries are free again. An eviction writeback from the tag side also fills the write-buffer entry and counts against its thread.

A single downstream issue port offers one pending entry at a time, with the miss entry taking precedence. When the bus takes the offer, the entry is either retired at once (for a write that expects no reply) or held as in service until its response arrives. Responses free the entry they belong to. When a non-fill response has a waiting requester, that requester gets a one-cycle reply. A thread squash removes the miss entry's requester, and frees the entry as well if it has not yet gone to the bus.

Top module: `blk_miss_buf`

## Requirements
- R1: The address offered on the issue port is the request or eviction address with its low log2(BLK_BYTES) bits forced to zero (6 bits with the default 64-byte block).
- R2: The command code is 0 for a read, 1 for a write and 2 for a write expecting no reply. A write is placed in the write-buffer entry when it is uncacheable, when `cfg_wr_alloc` is 0, or when its code is 2. Every other miss goes to the miss entry. `iss_sel` is 0 for the miss entry and 1 for the write-buffer entry.
- R3: One cycle after an entry is filled, that entry's blocked flag and bus request are both 1. `ready` is 1 exactly when neither blocked flag is set, and presenting a request while `ready` is 0 is a protocol error.
- R4: `iss_fill` is 1 for a cacheable miss-entry request and 0 for an uncacheable one and for every write-buffer entry.
- R5: While the miss entry is pending and not yet in service, the issue port offers it even if the write-buffer entry is also pending. Otherwise the port offers a pending write-buffer entry.
- R6: Taking an offer clears that entry's bus request. A code-2 write is freed at once and its blocked flag drops. Any other entry goes in service, stays blocked and is no longer offered.
- R7: A response with `rsp_fill`=1 frees the miss entry and produces no reply.
- R8: A response with `rsp_fill`=0 frees the write-buffer entry when `rsp_is_write`=1 and the miss entry otherwise. If that entry still has a requester, `resp_valid` pulses one cycle later with the entry's thread, carrying `rsp_data` for a read and zero for a write.
- R9: A squash whose thread matches a miss entry that is not in service frees it and clears its blocked flag and bus request. A squash for any other thread changes nothing.
- R10: A matching squash on an in-service miss entry leaves it blocked. Its later response frees it and produces no reply.
- R11: An eviction fills the write-buffer entry as a code-2 write, raises its blocked flag and bus request, and adds one to the eviction count of its thread, found at `wb_count[t*CW +: CW]`.
- R12: Synchronous active-high `rst` clears both entries, both blocked flags, both bus requests, the reply output and all per-thread counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request from the cache |
| req_addr | input | AW | Request byte address |
| req_cmd | input | 2 | 0 read, 1 write, 2 write with no reply |
| req_uncached | input | 1 | Request bypasses the cache |
| req_thread | input | TW | Requesting thread |
| cfg_wr_alloc | input | 1 | Write misses allocate a line |
| ready | output | 1 | No resource blocked; a miss may be presented |
| blk_miss | output | 1 | Blocked: miss entry occupied |
| blk_wb | output | 1 | Blocked: write-buffer entry occupied |
| bus_req_miss | output | 1 | Miss entry awaits the bus |
| bus_req_wb | output | 1 | Write-buffer entry awaits the bus |
| iss_valid | output | 1 | An entry is offered downstream |
| iss_sel | output | 1 | 0 miss entry, 1 write-buffer entry |
| iss_addr | output | AW | Block-aligned address of the offer |
| iss_cmd | output | 2 | Command code of the offer |
| iss_fill | output | 1 | Offer is a line fill |
| iss_take | input | 1 | Downstream accepts the offer |
| rsp_valid | input | 1 | Bus response |
| rsp_fill | input | 1 | Response is a line fill |
| rsp_is_write | input | 1 | Response belongs to a write |
| rsp_data | input | DW | Response data |
| resp_valid | output | 1 | Reply to the waiting requester |
| resp_thread | output | TW | Thread of the reply |
| resp_data | output | DW | Reply data (zero for writes) |
| sq_valid | input | 1 | Thread squash |
| sq_thread | input | TW | Squashed thread |
| ev_valid | input | 1 | Eviction writeback |
| ev_addr | input | AW | Eviction address |
| ev_thread | input | TW | Thread charged with the eviction |
| wb_count | output | NT*CW | Per-thread eviction counts |

## Verification
On every cycle the embedded properties check several local rules: that no miss arrives while blocked, that an eviction lands only in a free write buffer, and that a filled entry shows its blocked flag and bus request one cycle later. They also check that a taken offer drops its bus request, that a pending miss always wins the issue port, that a matching squash on an idle miss entry frees it, and that a miss response only reaches an in-service entry. Other behaviour can only be shown by the bench's scenarios: how the policy inputs steer each write, the line-fill tagging, the content and thread of each reply, the suppressed reply after a squash of an in-service entry, the per-thread counts, and a reset in the middle of traffic.

// File: rtl/mb_pkg.sv
package mb_pkg;
   typedef enum logic [1:0] {
      MB_RD    = 2'd0,
      MB_WR    = 2'd1,
      MB_WR_NR = 2'd2
   } mb_cmd_e;
endpackage

// File: rtl/mb_slot.sv
module mb_slot #(
   parameter int AW         = 32,
   parameter int TW         = 2,
   parameter bit CAN_SQUASH = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          alloc,
   input  logic [AW-1:0] a_addr,
   input  logic [1:0]    a_cmd,
   input  logic          a_fill,
   input  logic [TW-1:0] a_thread,
   input  logic          a_tgt,
   input  logic          issue,
   input  logic          release_i,
   input  logic          sq_valid,
   input  logic [TW-1:0] sq_thread,
   output logic          valid_o,
   output logic          insvc_o,
   output logic          req_o,
   output logic [AW-1:0] addr_o,
   output logic [1:0]    cmd_o,
   output logic          fill_o,
   output logic [TW-1:0] thread_o,
   output logic          tgt_o
);
   import mb_pkg::*;

   logic          valid_q, insvc_q, req_q, fill_q, tgt_q;
   logic [AW-1:0] addr_q;
   logic [1:0]    cmd_q;
   logic [TW-1:0] thread_q;
   logic          sq_hit;

   generate
      if (CAN_SQUASH) begin : g_sq
         assign sq_hit = sq_valid && valid_q && (sq_thread == thread_q);
      end else begin : g_nosq
         assign sq_hit = 1'b0 & sq_valid & (|sq_thread);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q  <= 1'b0;
         insvc_q  <= 1'b0;
         req_q    <= 1'b0;
         fill_q   <= 1'b0;
         tgt_q    <= 1'b0;
         addr_q   <= '0;
         cmd_q    <= '0;
         thread_q <= '0;
      end else if (alloc) begin
         valid_q  <= 1'b1;
         insvc_q  <= 1'b0;
         req_q    <= 1'b1;
         fill_q   <= a_fill;
         tgt_q    <= a_tgt;
         addr_q   <= a_addr;
         cmd_q    <= a_cmd;
         thread_q <= a_thread;
      end else if (release_i) begin
         valid_q <= 1'b0;
         insvc_q <= 1'b0;
         req_q   <= 1'b0;
         tgt_q   <= 1'b0;
      end else if (sq_hit) begin
         tgt_q <= 1'b0;
         if (!insvc_q) begin
            valid_q <= 1'b0;
            req_q   <= 1'b0;
         end
      end else if (issue) begin
         req_q <= 1'b0;
         if (cmd_q == MB_WR_NR) valid_q <= 1'b0;
         else                   insvc_q <= 1'b1;
      end
   end

   assign valid_o  = valid_q;
   assign insvc_o  = insvc_q;
   assign req_o    = req_q;
   assign addr_o   = addr_q;
   assign cmd_o    = cmd_q;
   assign fill_o   = fill_q;
   assign thread_o = thread_q;
   assign tgt_o    = tgt_q;

   // R6
   insvc_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
      insvc_q |-> valid_q);

   // R6
   no_double_alloc_chk: assert property (@(posedge clk) disable iff (rst)
      alloc |-> !valid_q);
endmodule

// File: rtl/mb_wb_ctr.sv
module mb_wb_ctr #(
   parameter int NT = 4,
   parameter int CW = 8,
   parameter int TW = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   input  logic [TW-1:0]    inc_thread,
   output logic [NT*CW-1:0] count_flat
);
   for (genvar t = 0; t < NT; t++) begin : g_thr
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (rst)                                 cnt_q <= '0;
         else if (inc && inc_thread == TW'(t))    cnt_q <= cnt_q + CW'(1);
      end
      assign count_flat[t*CW +: CW] = cnt_q;
   end
endmodule

// File: rtl/blk_miss_buf.sv
module blk_miss_buf #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int BLK_BYTES = 64,
   parameter int NT        = 4,
   parameter int CW        = 8,
   parameter int TW        = $clog2(NT)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic [AW-1:0]    req_addr,
   input  logic [1:0]       req_cmd,
   input  logic             req_uncached,
   input  logic [TW-1:0]    req_thread,
   input  logic             cfg_wr_alloc,
   output logic             ready,
   output logic             blk_miss,
   output logic             blk_wb,
   output logic             bus_req_miss,
   output logic             bus_req_wb,
   output logic             iss_valid,
   output logic             iss_sel,
   output logic [AW-1:0]    iss_addr,
   output logic [1:0]       iss_cmd,
   output logic             iss_fill,
   input  logic             iss_take,
   input  logic             rsp_valid,
   input  logic             rsp_fill,
   input  logic             rsp_is_write,
   input  logic [DW-1:0]    rsp_data,
   output logic             resp_valid,
   output logic [TW-1:0]    resp_thread,
   output logic [DW-1:0]    resp_data,
   input  logic             sq_valid,
   input  logic [TW-1:0]    sq_thread,
   input  logic             ev_valid,
   input  logic [AW-1:0]    ev_addr,
   input  logic [TW-1:0]    ev_thread,
   output logic [NT*CW-1:0] wb_count
);
   import mb_pkg::*;

   localparam int OFFW = $clog2(BLK_BYTES);
   localparam logic [AW-1:0] BLK_MASK = {{(AW-OFFW){1'b1}}, {OFFW{1'b0}}};

   initial begin
      blk_pow2_chk: assert (BLK_BYTES >= 2 && (BLK_BYTES & (BLK_BYTES - 1)) == 0);
      addr_fits_chk: assert (AW > OFFW);
      threads_chk: assert (NT >= 2 && TW >= $clog2(NT));
   end

   // entry outputs
   logic          m_valid, m_insvc, m_req, m_fill, m_tgt;
   logic [AW-1:0] m_addr;
   logic [1:0]    m_cmd;
   logic [TW-1:0] m_thread;
   logic          w_valid, w_insvc, w_req, w_fill, w_tgt;
   logic [AW-1:0] w_addr;
   logic [1:0]    w_cmd;
   logic [TW-1:0] w_thread;

   // request steering
   logic to_wb, req_acc, miss_alloc, wb_req_alloc, ev_acc, wb_alloc;
   logic [AW-1:0] wb_a_addr;
   logic [1:0]    wb_a_cmd;
   logic [TW-1:0] wb_a_thread;
   logic          wb_a_tgt;

   assign ready        = !m_valid && !w_valid;
   assign to_wb        = (req_cmd != MB_RD) &&
                         (req_uncached || !cfg_wr_alloc || req_cmd == MB_WR_NR);
   assign req_acc      = req_valid && ready;
   assign miss_alloc   = req_acc && !to_wb;
   assign wb_req_alloc = req_acc && to_wb;
   assign ev_acc       = ev_valid && !w_valid;
   assign wb_alloc     = wb_req_alloc || ev_acc;
   assign wb_a_addr    = (ev_acc ? ev_addr : req_addr) & BLK_MASK;
   assign wb_a_cmd     = ev_acc ? MB_WR_NR : req_cmd;
   assign wb_a_thread  = ev_acc ? ev_thread : req_thread;
   assign wb_a_tgt     = !ev_acc && (req_cmd != MB_WR_NR);

   // issue selection: a pending miss wins
   logic pick_miss, m_issue, w_issue;
   assign pick_miss = m_valid && !m_insvc;
   assign iss_valid = pick_miss || (w_valid && !w_insvc);
   assign iss_sel   = !pick_miss;
   assign iss_addr  = pick_miss ? m_addr : w_addr;
   assign iss_cmd   = pick_miss ? m_cmd  : w_cmd;
   assign iss_fill  = pick_miss ? m_fill : w_fill;
   assign m_issue   = iss_take && pick_miss;
   assign w_issue   = iss_take && !pick_miss && w_valid && !w_insvc;

   // response routing
   logic m_rel, w_rel, rsp_tgt, rsp_rd;
   logic [TW-1:0] rsp_thr;
   assign w_rel   = rsp_valid && !rsp_fill && rsp_is_write;
   assign m_rel   = rsp_valid && !w_rel;
   assign rsp_tgt = w_rel ? w_tgt : (m_tgt && !rsp_fill);
   assign rsp_rd  = (w_rel ? w_cmd : m_cmd) == MB_RD;
   assign rsp_thr = w_rel ? w_thread : m_thread;

   always_ff @(posedge clk) begin
      if (rst) begin
         resp_valid  <= 1'b0;
         resp_thread <= '0;
         resp_data   <= '0;
      end else begin
         resp_valid  <= rsp_valid && rsp_tgt;
         resp_thread <= rsp_thr;
         resp_data   <= rsp_rd ? rsp_data : '0;
      end
   end

   mb_slot #(.AW(AW), .TW(TW), .CAN_SQUASH(1'b1)) u_miss (
      .clk, .rst,
      .alloc(miss_alloc), .a_addr(req_addr & BLK_MASK), .a_cmd(req_cmd),
      .a_fill(!req_uncached), .a_thread(req_thread), .a_tgt(req_cmd != MB_WR_NR),
      .issue(m_issue), .release_i(m_rel), .sq_valid, .sq_thread,
      .valid_o(m_valid), .insvc_o(m_insvc), .req_o(m_req), .addr_o(m_addr),
      .cmd_o(m_cmd), .fill_o(m_fill), .thread_o(m_thread), .tgt_o(m_tgt));

   mb_slot #(.AW(AW), .TW(TW), .CAN_SQUASH(1'b0)) u_wbuf (
      .clk, .rst,
      .alloc(wb_alloc), .a_addr(wb_a_addr), .a_cmd(wb_a_cmd),
      .a_fill(1'b0), .a_thread(wb_a_thread), .a_tgt(wb_a_tgt),
      .issue(w_issue), .release_i(w_rel), .sq_valid, .sq_thread,
      .valid_o(w_valid), .insvc_o(w_insvc), .req_o(w_req), .addr_o(w_addr),
      .cmd_o(w_cmd), .fill_o(w_fill), .thread_o(w_thread), .tgt_o(w_tgt));

   mb_wb_ctr #(.NT(NT), .CW(CW), .TW(TW)) u_ctr (
      .clk, .rst, .inc(ev_acc), .inc_thread(ev_thread), .count_flat(wb_count));

   assign blk_miss     = m_valid;
   assign blk_wb       = w_valid;
   assign bus_req_miss = m_req;
   assign bus_req_wb   = w_req;

   // R3
   blocked_no_req_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid |-> ready);

   // R3
   miss_alloc_raise_chk: assert property (@(posedge clk) disable iff (rst)
      miss_alloc |=> blk_miss && bus_req_miss);

   // R3
   wb_alloc_raise_chk: assert property (@(posedge clk) disable iff (rst)
      wb_alloc |=> blk_wb && bus_req_wb);

   // R11
   ev_needs_free_chk: assert property (@(posedge clk) disable iff (rst)
      ev_valid |-> !blk_wb && !(req_valid && to_wb));

   // R5
   miss_first_chk: assert property (@(posedge clk) disable iff (rst)
      (blk_miss && bus_req_miss) |-> iss_valid && !iss_sel);

   // R6
   issue_drop_req_chk: assert property (@(posedge clk) disable iff (rst)
      (iss_take && iss_valid) |=> !($past(iss_sel) ? bus_req_wb : bus_req_miss));

   // R7
   rsp_in_service_chk: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !w_rel) |-> m_insvc);

   // R9
   squash_free_chk: assert property (@(posedge clk) disable iff (rst)
      (sq_valid && blk_miss && !m_insvc && sq_thread == m_thread && !rsp_valid)
      |=> !blk_miss && !bus_req_miss);
endmodule

// File: tb/blk_miss_buf_bench.sv
module blk_miss_buf_bench;
   localparam int AW = 32, DW = 32, NT = 4, CW = 8, TW = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst, req_valid, req_uncached, cfg_wr_alloc, iss_take;
   logic [AW-1:0] req_addr, ev_addr;
   logic [1:0] req_cmd;
   logic [TW-1:0] req_thread, sq_thread, ev_thread, resp_thread;
   logic ready, blk_miss, blk_wb, bus_req_miss, bus_req_wb, iss_valid, iss_sel, iss_fill;
   logic [AW-1:0] iss_addr;
   logic [1:0] iss_cmd;
   logic rsp_valid, rsp_fill, rsp_is_write, resp_valid, sq_valid, ev_valid;
   logic [DW-1:0] rsp_data, resp_data;
   logic [NT*CW-1:0] wb_count;

   blk_miss_buf #(.AW(AW), .DW(DW), .BLK_BYTES(64), .NT(NT), .CW(CW)) u_blk_miss_buf (
      .clk, .rst, .req_valid, .req_addr, .req_cmd, .req_uncached, .req_thread,
      .cfg_wr_alloc, .ready, .blk_miss, .blk_wb, .bus_req_miss, .bus_req_wb,
      .iss_valid, .iss_sel, .iss_addr, .iss_cmd, .iss_fill, .iss_take,
      .rsp_valid, .rsp_fill, .rsp_is_write, .rsp_data,
      .resp_valid, .resp_thread, .resp_data,
      .sq_valid, .sq_thread, .ev_valid, .ev_addr, .ev_thread, .wb_count);

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   typedef struct packed { logic [TW-1:0] thr; logic [DW-1:0] data; } rsp_item_t;
   rsp_item_t exp_q[$];

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(); @(negedge clk); endtask

   task automatic send(input logic [AW-1:0] a, input logic [1:0] c, input logic unc,
                       input logic [TW-1:0] t, input logic wa);
      req_addr = a; req_cmd = c; req_uncached = unc; req_thread = t; cfg_wr_alloc = wa;
      req_valid = 1'b1; tick(); req_valid = 1'b0;
   endtask

   task automatic take(); iss_take = 1'b1; tick(); iss_take = 1'b0; endtask

   task automatic respond(input logic f, input logic w, input logic [DW-1:0] d);
      rsp_fill = f; rsp_is_write = w; rsp_data = d;
      rsp_valid = 1'b1; tick(); rsp_valid = 1'b0;
   endtask

   task automatic squash(input logic [TW-1:0] t);
      sq_thread = t; sq_valid = 1'b1; tick(); sq_valid = 1'b0;
   endtask

   task automatic evict(input logic [AW-1:0] a, input logic [TW-1:0] t);
      ev_addr = a; ev_thread = t; ev_valid = 1'b1; tick(); ev_valid = 1'b0;
   endtask

   // monitor: replies are compared against the scoreboard
   always @(negedge clk) begin
      if (!rst && resp_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R10 unexpected reply", {32'h0, resp_data}, 64'h0);
         end else begin
            rsp_item_t e;
            e = exp_q.pop_front();
            chk(resp_data == e.data, "R8 reply data", resp_data, e.data);
            chk(resp_thread == e.thr, "R8 reply thread", resp_thread, e.thr);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; req_valid = 0; req_addr = 0; req_cmd = 0; req_uncached = 0;
      req_thread = 0; cfg_wr_alloc = 1; iss_take = 0; rsp_valid = 0; rsp_fill = 0;
      rsp_is_write = 0; rsp_data = 0; sq_valid = 0; sq_thread = 0; ev_valid = 0;
      ev_addr = 0; ev_thread = 0;
      tick(); tick(); rst = 1'b0; tick();

      // R12 reset state
      chk(ready && !blk_miss && !blk_wb && !bus_req_miss && !bus_req_wb && !iss_valid,
          "R12 reset outputs", {ready, blk_miss, blk_wb, bus_req_miss, bus_req_wb, iss_valid}, 6'b100000);
      chk(wb_count == '0, "R12 reset counts", wb_count, 0);

      // cacheable read -> miss entry, aligned, fill
      send(32'h1234_567F, 2'd0, 1'b0, 2'd1, 1'b1);
      chk(blk_miss && bus_req_miss && !blk_wb && !ready, "R3 miss raise",
          {blk_miss, bus_req_miss, blk_wb, ready}, 4'b1100);
      chk(iss_addr == 32'h1234_5640, "R1 aligned address", iss_addr, 32'h1234_5640);
      chk(iss_valid && iss_sel == 1'b0, "R2 read to miss entry", iss_sel, 0);
      chk(iss_fill == 1'b1, "R4 cacheable fill", iss_fill, 1);
      take();
      chk(!bus_req_miss && blk_miss && !iss_valid, "R6 in service",
          {bus_req_miss, blk_miss, iss_valid}, 3'b010);
      respond(1'b1, 1'b0, 32'hDEAD_0001);
      tick();
      chk(!blk_miss && ready, "R7 fill frees miss", {blk_miss, ready}, 2'b01);

      // uncached read -> reply with data
      send(32'h0000_1004, 2'd0, 1'b1, 2'd2, 1'b1);
      chk(iss_fill == 1'b0 && iss_sel == 1'b0, "R4 uncached no fill", {iss_fill, iss_sel}, 0);
      take();
      exp_q.push_back('{thr: 2'd2, data: 32'h0000_CAFE});
      respond(1'b0, 1'b0, 32'h0000_CAFE);
      chk(!blk_miss, "R8 read response frees miss", blk_miss, 0);
      tick();

      // cacheable write with allocation -> miss entry
      send(32'h0000_2010, 2'd1, 1'b0, 2'd0, 1'b1);
      chk(blk_miss && !blk_wb && iss_sel == 1'b0, "R2 allocating write to miss",
          {blk_miss, blk_wb, iss_sel}, 3'b100);
      take(); respond(1'b1, 1'b0, 0); tick();

      // write without allocation -> write buffer with reply
      send(32'h0000_3033, 2'd1, 1'b0, 2'd3, 1'b0);
      chk(blk_wb && bus_req_wb && !blk_miss && iss_sel == 1'b1 && iss_fill == 1'b0,
          "R2 no-alloc write to write buffer", {blk_wb, bus_req_wb, blk_miss, iss_sel, iss_fill}, 5'b11010);
      chk(iss_addr == 32'h0000_3000, "R1 write aligned", iss_addr, 32'h0000_3000);
      take();
      chk(blk_wb && !bus_req_wb && !iss_valid, "R6 write in service",
          {blk_wb, bus_req_wb, iss_valid}, 3'b100);
      exp_q.push_back('{thr: 2'd3, data: 32'h0});
      respond(1'b0, 1'b1, 32'h5555_5555);
      chk(!blk_wb && ready, "R8 write response frees buffer", {blk_wb, ready}, 2'b01);
      tick();

      // uncached write -> write buffer
      send(32'h0000_3800, 2'd1, 1'b1, 2'd0, 1'b1);
      chk(blk_wb && !blk_miss, "R2 uncached write to buffer", {blk_wb, blk_miss}, 2'b10);
      take(); exp_q.push_back('{thr: 2'd0, data: 32'h0});
      respond(1'b0, 1'b1, 0); tick();

      // no-reply write, cacheable with alloc -> buffer, freed on issue
      send(32'h0000_4000, 2'd2, 1'b0, 2'd1, 1'b1);
      chk(blk_wb && !blk_miss && iss_cmd == 2'd2, "R2 no-reply write to buffer",
          {blk_wb, blk_miss, iss_cmd}, 4'b1010);
      take();
      chk(!blk_wb && !bus_req_wb && ready, "R6 no-reply freed on issue",
          {blk_wb, bus_req_wb, ready}, 3'b001);

      // priority: miss pending + eviction pending
      send(32'h0000_5000, 2'd0, 1'b0, 2'd0, 1'b1);
      evict(32'h0000_6021, 2'd2);
      chk(blk_wb && bus_req_wb && blk_miss, "R11 eviction raise",
          {blk_wb, bus_req_wb, blk_miss}, 3'b111);
      chk(iss_sel == 1'b0 && iss_addr == 32'h0000_5000, "R5 miss wins", iss_sel, 0);
      take();
      chk(iss_valid && iss_sel == 1'b1 && iss_addr == 32'h0000_6000, "R5 buffer offered next",
          iss_addr, 32'h0000_6000);
      take();
      chk(!blk_wb && blk_miss, "R11 eviction freed on issue", {blk_wb, blk_miss}, 2'b01);
      chk(wb_count[2*CW +: CW] == 8'd1, "R11 thread 2 count", wb_count[2*CW +: CW], 1);
      respond(1'b1, 1'b0, 0); tick();

      // squash: mismatch then match while pending
      send(32'h0000_7000, 2'd0, 1'b1, 2'd1, 1'b1);
      squash(2'd3);
      chk(blk_miss && bus_req_miss, "R9 other thread no effect", {blk_miss, bus_req_miss}, 2'b11);
      squash(2'd1);
      chk(!blk_miss && !bus_req_miss && ready, "R9 squash frees",
          {blk_miss, bus_req_miss, ready}, 3'b001);

      // squash while in service: stays, response gives no reply
      send(32'h0000_8000, 2'd0, 1'b1, 2'd0, 1'b1);
      take();
      squash(2'd0);
      chk(blk_miss, "R10 in-service stays blocked", blk_miss, 1);
      respond(1'b0, 1'b0, 32'h7777_7777);
      chk(!blk_miss, "R10 response frees", blk_miss, 0);
      tick(); tick();

      // counts per thread
      evict(32'h0000_9000, 2'd3); take();
      evict(32'h0000_9040, 2'd3); take();
      chk(wb_count[3*CW +: CW] == 8'd2, "R11 thread 3 count", wb_count[3*CW +: CW], 2);
      chk(wb_count[0 +: CW] == 8'd0, "R11 thread 0 untouched", wb_count[0 +: CW], 0);

      // mid-traffic reset
      send(32'h0000_A000, 2'd0, 1'b0, 2'd1, 1'b1);
      rst = 1'b1; tick(); rst = 1'b0; tick();
      chk(ready && !blk_miss && !bus_req_miss && !iss_valid && wb_count == '0,
          "R12 mid-traffic reset", {ready, blk_miss, bus_req_miss, iss_valid}, 4'b1000);

      chk(exp_q.size() == 0, "R8 all replies seen", exp_q.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule